// File: doc/BRIEF.md
# I2C Slave Address Responder

This block is the target-side front end of a two-wire serial bus. While it is enabled it samples the clock and data lines through synchronizers, and it watches for a START condition. It then shifts in the first byte and compares the upper seven bits with a programmable own address and with the all-zero general call address. On a hit it pulls the data line low in the ninth clock to acknowledge. The direction bit of that byte then decides whether the block receives bytes from the bus controller or sends bytes to it.

Received bytes reach the host as a one-cycle strobe with the byte. In the sending direction, the block holds the clock line low before each byte until the host presents a byte. It then shifts that byte out, most significant bit first, and reads the controller's acknowledge. A not-acknowledge ends the transfer. Two flags tell the host how it was selected: a general-call flag and a direction flag. An address that matches neither target leaves the data line untouched until the next STOP or START.

Top module: `i2c_addr_responder`

## Requirements
- R1: After reset, and in the cycle after `enable` is low, `sda_oe` and `scl_hold` are 0. While disabled, `selected`, `gc_flag` and `dir_flag` read 0.
- R2: A falling SDA while SCL is high (START) begins capture of an address byte. A rising SDA while SCL is high (STOP) ends any transfer, so `selected` returns to 0.
- R3: First byte = {own_addr, 0}: the block drives SDA low during the ninth SCL pulse. `selected`=1, `dir_flag`=0 and `gc_flag`=0.
- R4: First byte = 0x00 (address 0, write): the block acknowledges and sets `gc_flag`=1 with `dir_flag`=0.
- R5: Any other first byte, including 0x01 (general call with the read bit), gets no acknowledge. No data byte is acknowledged or reported until the next STOP or START.
- R6: In the receive direction each byte is shifted in MSB first. `rx_valid` pulses for exactly one cycle with the byte on `rx_data`, and the block acknowledges in the ninth clock.
- R7: First byte = {own_addr, 1} sets `dir_flag`=1. Once the acknowledge has been given, `scl_hold` keeps SCL low until `tx_valid`. The `tx_data` byte is then sent MSB first, with `sda_oe`=1 for each 0 bit.
- R8: In the send direction, SDA is released in the acknowledge slot. A controller ACK (SDA low) causes SCL to be held again for the next byte. A NACK (SDA high) returns `selected` to 0 with SDA released.
- R9: A repeated START while selected clears the flags and restarts address matching.
- R10: `sda_oe` only rises while the synchronized SCL is low. A bit the block sends stays stable through the whole SCL high phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle |
| own_addr | input | 7 | Programmable own bus address |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_hold | output | 1 | 1 = pull SCL low (wait for host byte) |
| sda_oe | output | 1 | 1 = pull SDA low |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | Host presents `tx_data` |
| selected | output | 1 | Block is the addressed target |
| dir_flag | output | 1 | 1 = send direction chosen by controller |
| gc_flag | output | 1 | Selected by the general call address |

## Verification
Several properties are checked on every cycle:
- disabling releases both lines;
- the receive strobe is a single cycle and occurs only in the receive direction;
- the general-call flag never coexists with the send direction;
- the clock is held only while selected for sending;
- SDA is never newly pulled while SCL is high.

Address comparison, the acknowledge in the ninth clock, MSB-first byte order, the ignore behaviour after a mismatch, and the NACK and repeated START exits need complete bus transactions. Only the bench's scenarios show those.

// File: rtl/i2c_resp_pkg.sv
package i2c_resp_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BCNT_W = $clog2(BYTE_W + 1);
  localparam logic [ADDR_W-1:0] GC_ADDR = '0;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX_BYTE,
    ST_RX_ACK,
    ST_TX_WAIT,
    ST_TX_BYTE,
    ST_TX_ACK,
    ST_IGNORE
  } resp_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);
  logic [LINES-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '1;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_cond_det.sv
module i2c_cond_det (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
endmodule

// File: rtl/i2c_resp_fsm.sv
module i2c_resp_fsm
  import i2c_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              sda_s,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              sda_oe,
  output logic              scl_hold,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              gc_flag,
  output logic              dir_flag,
  output logic              selected
);
  localparam logic [BCNT_W-1:0] LAST_BIT = BCNT_W'(BYTE_W - 1);

  resp_state_e       state_q, state_d;
  logic [BCNT_W-1:0] bcnt_q, bcnt_d;
  logic [BYTE_W-1:0] shreg_q, shreg_d;
  logic [BYTE_W-1:0] rxd_q, rxd_d;
  logic              phase_q, phase_d;
  logic              sda_q, sda_d;
  logic              hold_q, hold_d;
  logic              rxv_q, rxv_d;
  logic              gc_q, gc_d;
  logic              dir_q, dir_d;
  logic              own_hit, gc_hit;

  always_comb begin
    state_d = state_q;
    bcnt_d  = bcnt_q;
    shreg_d = shreg_q;
    rxd_d   = rxd_q;
    phase_d = phase_q;
    sda_d   = sda_q;
    rxv_d   = 1'b0;
    gc_d    = gc_q;
    dir_d   = dir_q;
    own_hit = 1'b0;
    gc_hit  = 1'b0;

    if (!enable) begin
      state_d = ST_IDLE;
      bcnt_d  = '0;
      phase_d = 1'b0;
      sda_d   = 1'b0;
      gc_d    = 1'b0;
      dir_d   = 1'b0;
    end else if (start_i) begin
      state_d = ST_ADDR;
      bcnt_d  = '0;
      phase_d = 1'b0;
      sda_d   = 1'b0;
      gc_d    = 1'b0;
      dir_d   = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      phase_d = 1'b0;
      sda_d   = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: begin
          if (scl_rise_i) begin
            shreg_d = {shreg_q[BYTE_W-2:0], sda_s};
            bcnt_d  = bcnt_q + 1'b1;
            if (bcnt_q == LAST_BIT) begin
              own_hit = (shreg_d[BYTE_W-1:1] == own_addr);
              gc_hit  = (shreg_d[BYTE_W-1:1] == GC_ADDR) && !shreg_d[0];
              if (own_hit || gc_hit) begin
                state_d = ST_ADDR_ACK;
                phase_d = 1'b0;
                dir_d   = shreg_d[0];
                gc_d    = gc_hit && !own_hit;
              end else begin
                state_d = ST_IGNORE;
              end
            end
          end
        end
        ST_ADDR_ACK, ST_RX_ACK: begin
          if (scl_fall_i) begin
            if (!phase_q) begin
              sda_d   = 1'b1;
              phase_d = 1'b1;
            end else begin
              sda_d   = 1'b0;
              phase_d = 1'b0;
              bcnt_d  = '0;
              state_d = (state_q == ST_ADDR_ACK && dir_q) ? ST_TX_WAIT : ST_RX_BYTE;
            end
          end
        end
        ST_RX_BYTE: begin
          if (scl_rise_i) begin
            shreg_d = {shreg_q[BYTE_W-2:0], sda_s};
            bcnt_d  = bcnt_q + 1'b1;
            if (bcnt_q == LAST_BIT) begin
              rxd_d   = shreg_d;
              rxv_d   = 1'b1;
              phase_d = 1'b0;
              state_d = ST_RX_ACK;
            end
          end
        end
        ST_TX_WAIT: begin
          if (tx_valid) begin
            shreg_d = tx_data;
            sda_d   = ~tx_data[BYTE_W-1];
            bcnt_d  = '0;
            state_d = ST_TX_BYTE;
          end
        end
        ST_TX_BYTE: begin
          if (scl_fall_i) begin
            if (bcnt_q == LAST_BIT) begin
              sda_d   = 1'b0;
              phase_d = 1'b0;
              state_d = ST_TX_ACK;
            end else begin
              bcnt_d  = bcnt_q + 1'b1;
              shreg_d = {shreg_q[BYTE_W-2:0], 1'b0};
              sda_d   = ~shreg_d[BYTE_W-1];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise_i) begin
            if (sda_s) state_d = ST_IDLE;
            else       phase_d = 1'b1;
          end else if (scl_fall_i && phase_q) begin
            phase_d = 1'b0;
            state_d = ST_TX_WAIT;
          end
        end
        default: ;
      endcase
    end

    hold_d = enable && (state_q == ST_TX_WAIT) &&
             (state_d == ST_TX_WAIT || state_d == ST_TX_BYTE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bcnt_q  <= '0;
      shreg_q <= '0;
      rxd_q   <= '0;
      phase_q <= 1'b0;
      sda_q   <= 1'b0;
      hold_q  <= 1'b0;
      rxv_q   <= 1'b0;
      gc_q    <= 1'b0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      bcnt_q  <= bcnt_d;
      shreg_q <= shreg_d;
      phase_q <= phase_d;
      sda_q   <= sda_d;
      hold_q  <= hold_d;
      rxv_q   <= rxv_d;
      gc_q    <= gc_d;
      dir_q   <= dir_d;
      if (rxv_d) rxd_q <= rxd_d;
    end
  end

  assign sda_oe   = sda_q;
  assign scl_hold = hold_q;
  assign rx_data  = rxd_q;
  assign rx_valid = rxv_q;
  assign gc_flag  = gc_q;
  assign dir_flag = dir_q;
  assign selected = (state_q == ST_ADDR_ACK) || (state_q == ST_RX_BYTE) ||
                    (state_q == ST_RX_ACK)   || (state_q == ST_TX_WAIT) ||
                    (state_q == ST_TX_BYTE)  || (state_q == ST_TX_ACK);
endmodule

// File: rtl/i2c_addr_responder.sv
module i2c_addr_responder
  import i2c_resp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_hold,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              selected,
  output logic              dir_flag,
  output logic              gc_flag
);
  logic [1:0] rst_pipe;
  logic       rst_ns;
  logic [1:0] line_s;
  logic       scl_s, sda_s;
  logic       start_w, stop_w, rise_w, fall_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  i2c_line_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk   (clk),
    .rst_n (rst_ns),
    .d     ({sda_in, scl_in}),
    .q     (line_s)
  );
  assign scl_s = line_s[0];
  assign sda_s = line_s[1];

  i2c_cond_det cond_i (
    .clk        (clk),
    .rst_n      (rst_ns),
    .scl_s      (scl_s),
    .sda_s      (sda_s),
    .start_o    (start_w),
    .stop_o     (stop_w),
    .scl_rise_o (rise_w),
    .scl_fall_o (fall_w)
  );

  i2c_resp_fsm fsm_i (
    .clk        (clk),
    .rst_n      (rst_ns),
    .enable     (enable),
    .own_addr   (own_addr),
    .sda_s      (sda_s),
    .start_i    (start_w),
    .stop_i     (stop_w),
    .scl_rise_i (rise_w),
    .scl_fall_i (fall_w),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .sda_oe     (sda_oe),
    .scl_hold   (scl_hold),
    .rx_data    (rx_data),
    .rx_valid   (rx_valid),
    .gc_flag    (gc_flag),
    .dir_flag   (dir_flag),
    .selected   (selected)
  );
endmodule

// File: rtl/i2c_addr_responder_chk.sv
module i2c_addr_responder_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic sda_oe,
  input logic scl_hold,
  input logic rx_valid,
  input logic gc_flag,
  input logic dir_flag,
  input logic selected,
  input logic scl_s
);
  a_r1_disable_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!sda_oe && !scl_hold));

  a_r6_rx_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  a_r6_rx_only_receiving: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (selected && !dir_flag));

  a_r4_gc_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    gc_flag |-> !dir_flag);

  a_r7_hold_only_sending: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold |-> (selected && dir_flag));

  a_r10_pull_while_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);
endmodule

bind i2c_addr_responder i2c_addr_responder_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_ns),
  .enable   (enable),
  .sda_oe   (sda_oe),
  .scl_hold (scl_hold),
  .rx_valid (rx_valid),
  .gc_flag  (gc_flag),
  .dir_flag (dir_flag),
  .selected (selected),
  .scl_s    (scl_s)
);

// File: tb/i2c_addr_responder_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_responder_tb_top;
  localparam int H = 16;
  localparam logic [6:0] OWN = 7'h2A;

  logic       clk;
  logic       rst_n;
  logic       enable;
  logic       scl_m, sda_m;
  logic       scl_line, sda_line;
  logic       scl_hold, sda_oe;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       selected, dir_flag, gc_flag;

  int total = 0;
  int bad   = 0;
  logic [7:0] rx_log [16];
  int rx_cnt = 0;
  logic [7:0] tx_q [4];
  int tx_idx = 0;
  int hold_ok = 0;

  assign scl_line = scl_m & ~scl_hold;
  assign sda_line = sda_m & ~sda_oe;

  i2c_addr_responder dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .own_addr (OWN),
    .scl_in   (scl_line),
    .sda_in   (sda_line),
    .scl_hold (scl_hold),
    .sda_oe   (sda_oe),
    .rx_data  (rx_data),
    .rx_valid (rx_valid),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .selected (selected),
    .dir_flag (dir_flag),
    .gc_flag  (gc_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rx_valid && rx_cnt < 16) begin
      rx_log[rx_cnt] = rx_data;
      rx_cnt++;
    end
  end

  initial begin
    tx_valid = 1'b0;
    tx_data  = '0;
    forever begin
      @(negedge clk);
      if (scl_hold) begin
        wt(8);
        if (scl_line == 1'b0) hold_ok++;
        tx_data  = tx_q[tx_idx];
        tx_valid = 1'b1;
        @(negedge clk);
        tx_valid = 1'b0;
        tx_idx++;
        while (scl_hold) @(negedge clk);
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b0; wt(H);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(H);
    scl_m = 1'b1; wt(H);
    sda_m = 1'b1; wt(H);
  endtask

  task automatic write_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(H);
      scl_m = 1'b1;
      wait (scl_line == 1'b1);
      wt(H);
      scl_m = 1'b0; wt(H);
    end
    sda_m = 1'b1; wt(H);
    scl_m = 1'b1; wt(H/2);
    acked = !sda_line;
    wt(H/2);
    scl_m = 1'b0; wt(H);
  endtask

  task automatic read_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      logic s1;
      wt(H);
      scl_m = 1'b1;
      wait (scl_line == 1'b1);
      wt(H/2);
      s1 = sda_line;
      wt(H/2);
      check(s1 == sda_line, "R10 bit stable while SCL high", int'(sda_line), int'(s1));
      b[i] = sda_line;
      scl_m = 1'b0;
    end
    wt(H);
    sda_m = !give_ack; wt(H);
    scl_m = 1'b1; wt(H);
    scl_m = 1'b0; wt(H/2);
    sda_m = 1'b1; wt(H/2);
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0 && scl_hold == 1'b0, "R1 lines released after reset",
          int'({sda_oe, scl_hold}), 0);
    check(!selected && !gc_flag && !dir_flag, "R1 flags clear after reset",
          int'({selected, gc_flag, dir_flag}), 0);
  endtask

  task automatic t_own_write();
    bit ack;
    int base = rx_cnt;
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    check(ack, "R3 own address write acknowledged", int'(ack), 1);
    check(selected && !dir_flag && !gc_flag, "R3 flags after own write match",
          int'({selected, dir_flag, gc_flag}), 4);
    write_byte(8'hA5, ack);
    check(ack, "R6 data byte acknowledged", int'(ack), 1);
    write_byte(8'h3C, ack);
    check(rx_cnt == base + 2, "R6 one strobe per byte", rx_cnt - base, 2);
    check(rx_log[base] == 8'hA5, "R6 first byte MSB first", int'(rx_log[base]), 'hA5);
    check(rx_log[base+1] == 8'h3C, "R6 second byte", int'(rx_log[base+1]), 'h3C);
    bus_stop();
    wt(4);
    check(!selected, "R2 STOP ends transfer", int'(selected), 0);
  endtask

  task automatic t_general_call();
    bit ack;
    int base = rx_cnt;
    bus_start();
    write_byte(8'h00, ack);
    check(ack, "R4 general call acknowledged", int'(ack), 1);
    check(gc_flag && !dir_flag, "R4 general call flag", int'({gc_flag, dir_flag}), 2);
    write_byte(8'h81, ack);
    check(rx_cnt == base + 1 && rx_log[base] == 8'h81, "R4 general call data",
          int'(rx_log[base]), 'h81);
    bus_stop();
    wt(4);
  endtask

  task automatic t_mismatch();
    bit ack;
    int base = rx_cnt;
    bus_start();
    write_byte(8'h26, ack);
    check(!ack, "R5 foreign address not acknowledged", int'(ack), 0);
    write_byte(8'h00, ack);
    check(!ack && rx_cnt == base, "R5 traffic ignored after mismatch",
          rx_cnt - base, 0);
    check(!selected, "R5 not selected", int'(selected), 0);
    bus_stop();
    wt(4);
    bus_start();
    write_byte(8'h01, ack);
    check(!ack && !gc_flag, "R5 general call with read bit refused",
          int'({ack, gc_flag}), 0);
    bus_stop();
    wt(4);
  endtask

  task automatic t_own_read();
    bit ack;
    logic [7:0] b;
    int loads0 = tx_idx;
    tx_q[0] = 8'h5A;
    tx_q[1] = 8'hC3;
    tx_idx  = 0;
    hold_ok = 0;
    loads0  = 0;
    bus_start();
    write_byte({OWN, 1'b1}, ack);
    check(ack && dir_flag && !gc_flag, "R7 own read acknowledged with direction",
          int'({ack, dir_flag, gc_flag}), 6);
    read_byte(1'b1, b);
    check(b == 8'h5A, "R7 first sent byte", int'(b), 'h5A);
    read_byte(1'b0, b);
    check(b == 8'hC3, "R8 second byte after controller ACK", int'(b), 'hC3);
    check(tx_idx == loads0 + 2 && hold_ok == 2, "R7 SCL held until host byte",
          tx_idx, 2);
    wt(2);
    check(!selected && !sda_oe && !scl_hold, "R8 NACK ends sending",
          int'({selected, sda_oe, scl_hold}), 0);
    bus_stop();
    wt(4);
  endtask

  task automatic t_repeated_start();
    bit ack;
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    check(ack && selected, "R9 selected before repeated START", int'(selected), 1);
    bus_start();
    wt(2);
    check(!selected && !gc_flag && !dir_flag, "R9 repeated START restarts matching",
          int'(selected), 0);
    write_byte(8'h00, ack);
    check(ack && gc_flag, "R9 new address after repeated START", int'(gc_flag), 1);
    bus_stop();
    wt(4);
  endtask

  task automatic t_disable();
    bit ack;
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    enable = 1'b0;
    wt(4);
    check(!selected && !sda_oe && !scl_hold && !gc_flag && !dir_flag,
          "R1 disable forces idle", int'({selected, sda_oe, scl_hold}), 0);
    write_byte(8'h55, ack);
    check(!ack, "R1 no acknowledge while disabled", int'(ack), 0);
    enable = 1'b1;
    bus_stop();
    wt(4);
  endtask

  initial begin
    rst_n  = 1'b0;
    enable = 1'b1;
    scl_m  = 1'b1;
    sda_m  = 1'b1;
    wt(5);
    rst_n = 1'b1;
    wt(10);
    t_reset();
    t_own_write();
    t_general_call();
    t_mismatch();
    t_own_read();
    t_repeated_start();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule